// File: doc/BRIEF.md
# Paged Bit-Serial DRAM Controller

This block moves one page of single-bit speech samples between a codec sequencer and attached x1 dynamic RAM. A page is 1024 bits. The sequencer supplies a page number, a direction (store or play) and a strobe once per codec bit period. The block forms a 22-bit bit address from the page number and a 10-bit offset within the page. It runs one full RAS/CAS cycle per bit and splits the address into row and column halves on a shared address bus. It also inserts CAS-before-RAS refresh cycles on a fixed schedule, whether or not a page is in progress.

A memory-size input picks the memory arrangement. In large mode a single 4-Mbit device is attached, and a dual-purpose pin carries the eleventh address line. In small mode one or two 1-Mbit devices are attached, and the same pin becomes the row strobe of the second device. When the codec is powered down during a store, the sequencer sets the idle-fill input and the page is written with an alternating pattern.

Top module: `page_dram_ctrl`

## Requirements
- R1: After a start accepted while idle, `busy` stays high until exactly 1024 bit accesses have run. `done` is then high for exactly one cycle, and `busy` falls in that same cycle.
- R2: Large mode (`size_4m`=1). The bit address MA is page*1024 + offset. Row MA[21:11] is placed on {`a10_or_ras2_n`, `dram_addr`} when `ras_n` falls, and column MA[10:0] is placed on the same lines when `cas_n` falls.
- R3: Small mode (`size_4m`=0). Row MA[19:10] and column MA[9:0] are placed on `dram_addr`. When MA[20] is 0 the access strobes `ras_n`; when MA[20] is 1 it strobes `a10_or_ras2_n` instead. Page bit 11 has no effect in this mode.
- R4: In a store access, `we_n` is low and `dq_oe` is high while `cas_n` falls, and `dq_out` carries the `wr_bit` value captured with that bit's strobe. In a play access, `we_n` stays high and `dq_oe` stays low. The bit read from `dq_in` appears on `rd_bit` with a one-cycle `rd_valid` pulse, in offset order.
- R5: A store started with `idle_fill`=1 writes 1 at even offsets and 0 at odd offsets, whatever `wr_bit` carries.
- R6: Refresh is CAS-before-RAS: `cas_n` is low for at least one cycle before the row strobe falls. In small mode, both row strobes fall together during refresh. Refresh runs while idle as well as during a page.
- R7: A pending refresh is served before a pending data access. The gap between consecutive refresh cycles never exceeds REF_PERIOD+6 clocks.
- R8: During and after reset, `ras_n`, `cas_n` and `we_n` are high, and `dq_oe`, `busy`, `done` and `rd_valid` are low.
- R9: A start pulse while `busy` is high is ignored. The page, direction and offset of the running transfer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_4m | input | 1 | 1: one 4-Mbit device; 0: one or two 1-Mbit devices |
| start | input | 1 | Begin a page transfer (accepted while idle) |
| page_num | input | 12 | Page to transfer |
| store_mode | input | 1 | 1: store into memory; 0: play from memory |
| idle_fill | input | 1 | Store the alternating pattern instead of `wr_bit` |
| bit_stb | input | 1 | One pulse per codec bit period |
| wr_bit | input | 1 | Data bit to store, captured with `bit_stb` |
| rd_bit | output | 1 | Bit read from memory |
| rd_valid | output | 1 | One-cycle qualifier for `rd_bit` |
| busy | output | 1 | Page transfer in progress |
| done | output | 1 | One-cycle pulse when the page completes |
| dram_addr | output | 10 | Multiplexed row/column address lines 0..9 |
| a10_or_ras2_n | output | 1 | Address line 10 (large mode) or second row strobe, active low (small mode) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 1 | Data to memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 1 | Data from memory |

## Verification
Several properties are checked on every cycle: the order of column and row strobes in refresh, the bound on how long a refresh request waits, that write enable appears only in store accesses, that both row strobes are low together only with CAS already low, and that `done` is a single pulse. The bench's scenarios, run against a behavioural memory, are needed for the rest. They cover the address split in both modes, the device choice made by page bit 10, the data actually landing in and coming back from the right cells, the alternating fill, the refresh spacing, and a second start being ignored.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_HOLD,
    ST_PRE,
    ST_RCAS,
    ST_RRAS,
    ST_RHOLD,
    ST_RPRE
  } pdc_state_e;
endpackage

// File: rtl/pdc_ref_timer.sv
module pdc_ref_timer #(
  parameter int REF_PERIOD = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic req
);
  localparam int CW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(REF_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;

  always_comb begin
    cnt_d = cnt_q - CW'(1);
    req_d = req_q;
    if (ack) req_d = 1'b0;
    if (cnt_q == '0) begin
      cnt_d = RELOAD;
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (!req_q) age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  // R7
  ref_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_q <= 3'd5);
endmodule

// File: rtl/pdc_addr_map.sv
module pdc_addr_map #(
  parameter int MA_W = 22
) (
  input  logic [MA_W-1:0]   ma,
  input  logic              size_4m,
  input  logic              col_ph,
  output logic [MA_W/2-2:0] addr,
  output logic              hi_bit,
  output logic              dev
);
  localparam int HALF = MA_W / 2;
  localparam int SW   = HALF - 1;

  logic [HALF-1:0] row_l, col_l;
  logic [SW-1:0]   row_s, col_s;

  always_comb begin
    row_l = ma[MA_W-1:HALF];
    col_l = ma[HALF-1:0];
    row_s = ma[2*SW-1:SW];
    col_s = ma[SW-1:0];
    dev   = ma[2*SW];
    if (size_4m) addr = col_ph ? col_l[SW-1:0] : row_l[SW-1:0];
    else         addr = col_ph ? col_s : row_s;
    hi_bit = col_ph ? col_l[HALF-1] : row_l[HALF-1];
  end
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_req,
  input  logic acc_req,
  input  logic store,
  output logic ref_ack,
  output logic acc_go,
  output logic acc_end,
  output logic ras_acc,
  output logic ras_ref,
  output logic cas_on,
  output logic col_ph,
  output logic we_on
);
  pdc_state_e state_q, state_d;
  logic ras_acc_q, ras_ref_q, cas_on_q, col_ph_q, we_on_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ref_req) state_d = ST_RCAS;
                else if (acc_req) state_d = ST_ROW;
      ST_ROW:   state_d = ST_COL;
      ST_COL:   state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_PRE;
      ST_PRE:   state_d = ST_IDLE;
      ST_RCAS:  state_d = ST_RRAS;
      ST_RRAS:  state_d = ST_RHOLD;
      ST_RHOLD: state_d = ST_RPRE;
      ST_RPRE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ref_ack = (state_q == ST_IDLE) && ref_req;
  assign acc_go  = (state_q == ST_IDLE) && !ref_req && acc_req;
  assign acc_end = (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ras_acc_q <= 1'b0;
      ras_ref_q <= 1'b0;
      cas_on_q  <= 1'b0;
      col_ph_q  <= 1'b0;
      we_on_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      ras_acc_q <= state_d inside {ST_ROW, ST_COL, ST_HOLD};
      ras_ref_q <= state_d inside {ST_RRAS, ST_RHOLD};
      cas_on_q  <= state_d inside {ST_COL, ST_HOLD, ST_RCAS, ST_RRAS, ST_RHOLD};
      col_ph_q  <= state_d inside {ST_COL, ST_HOLD};
      we_on_q   <= store && (state_d inside {ST_ROW, ST_COL, ST_HOLD});
    end
  end

  assign ras_acc = ras_acc_q;
  assign ras_ref = ras_ref_q;
  assign cas_on  = cas_on_q;
  assign col_ph  = col_ph_q;
  assign we_on   = we_on_q;

  // R6
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_ref_q) |-> $past(cas_on_q));

  // R4
  we_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_on_q |-> store);

  // R7
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ref_req && acc_req) |=> (cas_on_q && !ras_acc_q));
endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl #(
  parameter int PAGE_W     = 12,
  parameter int OFF_W      = 10,
  parameter int REF_PERIOD = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        size_4m,
  input  logic                        start,
  input  logic [PAGE_W-1:0]           page_num,
  input  logic                        store_mode,
  input  logic                        idle_fill,
  input  logic                        bit_stb,
  input  logic                        wr_bit,
  output logic                        rd_bit,
  output logic                        rd_valid,
  output logic                        busy,
  output logic                        done,
  output logic [(PAGE_W+OFF_W)/2-2:0] dram_addr,
  output logic                        a10_or_ras2_n,
  output logic                        ras_n,
  output logic                        cas_n,
  output logic                        we_n,
  output logic                        dq_out,
  output logic                        dq_oe,
  input  logic                        dq_in
);
  localparam int MA_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] OFF_LAST = '1;

  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic ref_req, ref_ack, acc_go, acc_end;
  logic ras_acc, ras_ref, cas_on, col_ph, we_on;

  logic              busy_q, busy_d, store_q, store_d, fill_q, fill_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              pend_q, pend_d, data_q, data_d, wbit_q, wbit_d;
  logic              rdb_q, rdb_d, rdv_q, rdv_d, done_q, done_d;

  pdc_ref_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_s), .ack(ref_ack), .req(ref_req));

  pdc_seq u_seq (
    .clk(clk), .rst_n(rst_s), .ref_req(ref_req), .acc_req(pend_q),
    .store(store_q), .ref_ack(ref_ack), .acc_go(acc_go), .acc_end(acc_end),
    .ras_acc(ras_acc), .ras_ref(ras_ref), .cas_on(cas_on), .col_ph(col_ph),
    .we_on(we_on));

  logic [MA_W/2-2:0] map_addr;
  logic              map_hi, map_dev;

  pdc_addr_map #(.MA_W(MA_W)) u_map (
    .ma({page_q, off_q}), .size_4m(size_4m), .col_ph(col_ph),
    .addr(map_addr), .hi_bit(map_hi), .dev(map_dev));

  always_comb begin
    busy_d  = busy_q;
    store_d = store_q;
    fill_d  = fill_q;
    page_d  = page_q;
    off_d   = off_q;
    pend_d  = pend_q;
    data_d  = data_q;
    wbit_d  = wbit_q;
    rdb_d   = rdb_q;
    rdv_d   = 1'b0;
    done_d  = 1'b0;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      store_d = store_mode;
      fill_d  = idle_fill;
      page_d  = page_num;
      off_d   = '0;
      pend_d  = 1'b0;
    end
    if (acc_go) begin
      pend_d = 1'b0;
      wbit_d = fill_q ? ~off_q[0] : data_q;
    end
    if (bit_stb && busy_q) begin
      pend_d = 1'b1;
      data_d = wr_bit;
    end
    if (acc_end) begin
      off_d = off_q + OFF_W'(1);
      if (!store_q) begin
        rdb_d = dq_in;
        rdv_d = 1'b1;
      end
      if (off_q == OFF_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q  <= 1'b0;
      store_q <= 1'b0;
      fill_q  <= 1'b0;
      page_q  <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      data_q  <= 1'b0;
      wbit_q  <= 1'b0;
      rdb_q   <= 1'b0;
      rdv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      store_q <= store_d;
      fill_q  <= fill_d;
      page_q  <= page_d;
      off_q   <= off_d;
      pend_q  <= pend_d;
      data_q  <= data_d;
      wbit_q  <= wbit_d;
      rdb_q   <= rdb_d;
      rdv_q   <= rdv_d;
      done_q  <= done_d;
    end
  end

  logic strobe1, strobe2;
  assign strobe1 = ras_ref || (ras_acc && (size_4m || !map_dev));
  assign strobe2 = ras_ref || (ras_acc && map_dev);

  assign dram_addr     = map_addr;
  assign a10_or_ras2_n = size_4m ? map_hi : ~strobe2;
  assign ras_n         = ~strobe1;
  assign cas_n         = ~cas_on;
  assign we_n          = ~we_on;
  assign dq_oe         = we_on;
  assign dq_out        = wbit_q;
  assign rd_bit        = rdb_q;
  assign rd_valid      = rdv_q;
  assign busy          = busy_q;
  assign done          = done_q;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);

  // R3
  dual_ras_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!size_4m && !ras_n && !a10_or_ras2_n) |-> !cas_n);

  // R9
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> $stable(page_q));
endmodule

// File: tb/test_page_dram_ctrl.sv
module test_page_dram_ctrl;
  localparam int REF_P = 15;
  localparam int GAP_MAX = REF_P + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic size_4m = 1'b1, start = 1'b0, store_mode = 1'b0, idle_fill = 1'b0;
  logic bit_stb = 1'b0, wr_bit = 1'b0;
  logic [11:0] page_num = '0;
  logic rd_bit, rd_valid, busy, done, a10_or_ras2_n, ras_n, cas_n, we_n;
  logic dq_out, dq_oe;
  logic dq_in;
  logic [9:0] dram_addr;

  always #10 clk = ~clk;

  page_dram_ctrl #(.REF_PERIOD(REF_P)) i_page_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .size_4m(size_4m), .start(start),
    .page_num(page_num), .store_mode(store_mode), .idle_fill(idle_fill),
    .bit_stb(bit_stb), .wr_bit(wr_bit), .rd_bit(rd_bit), .rd_valid(rd_valid),
    .busy(busy), .done(done), .dram_addr(dram_addr),
    .a10_or_ras2_n(a10_or_ras2_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int checks = 0, fails = 0, cyc = 0;
  bit mem [int];
  bit rd_arr [1024];
  int rd_cnt, done_cnt, wr_cnt, r1_acc, r2_acc, ref_cnt, ref_err, oe_err;
  int last_ref = -1, max_gap = 0, row_key = 0;
  bit p_ras = 1, p_ras2 = 1, p_cas = 1, dq_r = 0;
  assign dq_in = dq_r;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // behavioural x1 memory and pin monitor
  always @(negedge clk) begin
    bit ras2;
    int key;
    ras2 = size_4m ? 1'b1 : a10_or_ras2_n;
    if (rd_valid && rd_cnt < 1024) begin rd_arr[rd_cnt] = rd_bit; rd_cnt++; end
    if (done) done_cnt++;
    if (p_ras && !ras_n) begin
      if (!cas_n) begin
        ref_cnt++;
        if (!size_4m && !(p_ras2 && !ras2)) ref_err++;
        if (last_ref >= 0 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
        last_ref = cyc;
      end else begin
        r1_acc++;
        row_key = size_4m ? int'({a10_or_ras2_n, dram_addr}) : int'(dram_addr);
      end
    end
    if (!size_4m && p_ras2 && !ras2 && cas_n) begin
      r2_acc++;
      row_key = (1 << 11) | int'(dram_addr);
    end
    if (p_cas && !cas_n && !(ras_n && ras2)) begin
      if (size_4m) key = (row_key << 11) | int'({a10_or_ras2_n, dram_addr});
      else key = ((row_key >> 11) << 22) | ((row_key & 1023) << 11) | int'(dram_addr);
      if (!we_n) begin
        if (!dq_oe) oe_err++;
        mem[key] = dq_out;
        wr_cnt++;
      end else begin
        dq_r = mem.exists(key) ? mem[key] : 1'b0;
      end
    end
    p_ras = ras_n; p_ras2 = ras2; p_cas = cas_n;
  end

  function automatic int exp_key(input bit s4, input int pg, input int off);
    int ma;
    ma = pg * 1024 + off;
    if (s4) return ma;
    return (((ma >> 20) & 1) << 22) | (((ma >> 10) & 1023) << 11) | (ma & 1023);
  endfunction

  function automatic bit pat(input int pg, input int off);
    return bit'(((off * 13 + pg * 5) >> 3) & 1) ^ (off % 3 == 0);
  endfunction

  task automatic run_page(input int pg, input bit st, input bit fl, input int seed,
                          input int restart_at, input int restart_pg);
    rd_cnt = 0; done_cnt = 0; wr_cnt = 0; r1_acc = 0; r2_acc = 0;
    @(posedge clk); #1;
    page_num = 12'(pg); store_mode = st; idle_fill = fl; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      if (i == restart_at) begin
        page_num = 12'(restart_pg); store_mode = ~st; start = 1'b1;
      end
      wr_bit = fl ? ~pat(seed, i) : pat(seed, i);
      bit_stb = 1'b1;
      @(posedge clk); #1; bit_stb = 1'b0; start = 1'b0;
      repeat (9) @(posedge clk);
      #1;
    end
    repeat (14) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(ras_n && cas_n && we_n, "R8 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!dq_oe && !busy && !done && !rd_valid, "R8 flags in reset",
        {dq_oe, busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(ras_n && cas_n && we_n && !busy, "R8 after reset",
        {ras_n, cas_n, we_n, busy}, 14);
  endtask

  task automatic t_idle_refresh;
    int c0;
    c0 = ref_cnt;
    repeat (300) @(posedge clk);
    #1;
    chk(ref_cnt - c0 >= 300 / GAP_MAX, "R6 refresh while idle", ref_cnt - c0, 300 / GAP_MAX);
  endtask

  task automatic t_store_play_large;
    int bad;
    size_4m = 1'b1;
    run_page(2900, 1'b1, 1'b0, 2900, -1, 0);
    chk(done_cnt == 1 && !busy, "R1 one done per page", done_cnt, 1);
    chk(wr_cnt == 1024, "R4 writes per store page", wr_cnt, 1024);
    chk(oe_err == 0, "R4 dq_oe during write", oe_err, 0);
    bad = 0;
    for (int o = 0; o < 1024; o++) begin
      int k;
      k = exp_key(1'b1, 2900, o);
      if (!mem.exists(k) || mem[k] != pat(2900, o)) bad++;
    end
    chk(bad == 0, "R2 large-mode cell placement", bad, 0);
    run_page(2900, 1'b0, 1'b0, 0, -1, 0);
    chk(wr_cnt == 0, "R4 no write during play", wr_cnt, 0);
    chk(rd_cnt == 1024, "R4 rd_valid count", rd_cnt, 1024);
    bad = 0;
    for (int o = 0; o < 1024; o++) if (rd_arr[o] != pat(2900, o)) bad++;
    chk(bad == 0, "R4 play data order", bad, 0);
    chk(done_cnt == 1, "R1 done after play", done_cnt, 1);
  endtask

  task automatic t_fill;
    int bad;
    size_4m = 1'b1;
    run_page(77, 1'b1, 1'b1, 77, -1, 0);
    bad = 0;
    for (int o = 0; o < 1024; o++) begin
      int k;
      k = exp_key(1'b1, 77, o);
      if (!mem.exists(k) || mem[k] != ((o % 2) == 0)) bad++;
    end
    chk(bad == 0, "R5 alternating fill", bad, 0);
  endtask

  task automatic t_small_mode;
    int bad;
    size_4m = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    run_page(1024 + 300, 1'b1, 1'b0, 555, -1, 0);
    chk(r1_acc == 0 && r2_acc == 1024, "R3 second device strobe", r2_acc, 1024);
    bad = 0;
    for (int o = 0; o < 1024; o++) begin
      int k;
      k = exp_key(1'b0, 1024 + 300, o);
      if (!mem.exists(k) || mem[k] != pat(555, o)) bad++;
    end
    chk(bad == 0, "R3 small-mode cell placement", bad, 0);
    run_page(2048 + 1024 + 300, 1'b0, 1'b0, 0, -1, 0);
    bad = 0;
    for (int o = 0; o < 1024; o++) if (rd_arr[o] != pat(555, o)) bad++;
    chk(bad == 0 && rd_cnt == 1024, "R3 page bit 11 ignored", bad, 0);
    run_page(300, 1'b1, 1'b0, 9, -1, 0);
    chk(r2_acc == 0 && r1_acc == 1024, "R3 first device strobe", r1_acc, 1024);
    chk(ref_err == 0, "R6 both strobes refresh", ref_err, 0);
  endtask

  task automatic t_restart_ignored;
    int bad;
    size_4m = 1'b0;
    run_page(400, 1'b1, 1'b0, 400, 100, 600);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    chk(wr_cnt == 1024, "R9 direction kept", wr_cnt, 1024);
    bad = 0;
    for (int o = 0; o < 1024; o++) begin
      int k;
      k = exp_key(1'b0, 400, o);
      if (!mem.exists(k) || mem[k] != pat(400, o)) bad++;
    end
    chk(bad == 0, "R9 page kept", bad, 0);
    chk(!mem.exists(exp_key(1'b0, 600, 0)), "R9 other page untouched", 1, 0);
  endtask

  initial begin
    t_reset();
    t_idle_refresh();
    t_store_play_large();
    t_fill();
    t_small_mode();
    t_restart_ignored();
    chk(max_gap <= GAP_MAX && ref_cnt > 0, "R7 refresh spacing", max_gap, GAP_MAX);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule